// File: doc/BRIEF.md
# Six-Bit Bidirectional GPIO Port

This block controls a six-bit bidirectional general-purpose I/O port. Each pin has a direction bit, an output latch bit and a synchronized input path. A simple register bus reaches the block through three select strobes: port, direction and analog configuration. It also carries a write strobe, an operation code for full writes or single-bit set and clear, a bit index, write data and a combinational read-data mux. Pin drivers come out as separate output-enable and output-value vectors, ready for a tristate pad wrapper.

A port read returns the synchronized pin levels, not the latch. Single-bit set and clear are therefore read-modify-write operations built on the pin levels. Every pin except bit 4 can be put into analog mode, and an analog pin reads as 0 on the digital path. Bit 4 has an open-drain output. Its synchronized input is also brought out as a timer clock tap. Reset leaves every pin as an input and every analog-capable pin in analog mode.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the direction register holds all ones and the output latch holds zero. Analog mode is set on bits 0-3 and 5. No output enable is active, a port read returns 0x00, a direction read returns 0x3F and an analog read returns 0x2F.
- R2: For bits 0-3 and 5, a direction bit of 1 deasserts that pin's output enable. A direction bit of 0 asserts the output enable and drives the latch bit onto the pin's output value.
- R3: A port read (port_sel_i high) returns {2'b00, synchronized pins with analog bits forced to 0}. It never returns the latch contents.
- R4: A write with port_sel_i and op_i = 2'b00 loads wdata_i[5:0] into the output latch.
- R5: op_i = 2'b01 (set) or 2'b10 (clear) with port_sel_i loads the latch with the current port read value, with bit bit_idx_i forced to 1 or 0. When bit_idx_i is 6 or 7, or op_i = 2'b11, the latch is unchanged.
- R6: On bit 4, the output value is always 0. The output enable on bit 4 is asserted only when both its direction bit and its latch bit are 0.
- R7: tmr_clk_o carries pin 4 through a two-flop synchronizer. A pin change shows on tmr_clk_o and on the port read after the second rising clock edge, and not after the first.
- R8: A 1 in the analog register bit of a pin forces that pin's port read bit to 0, and also its value in set/clear read-modify-write. Analog bit 4 and bits 7:6 do not exist: writes to them are ignored and they read as 0.
- R9: A direction write loads wdata_i[5:0]. A direction read returns {2'b00, direction}.
- R10: Analog mode does not disable the driver. A pin with analog bit 1 and direction bit 0 still has its output enable asserted.
- R11: The read mux gives priority to port, then direction, then analog. With no select high, rdata_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_sel_i | input | 1 | Selects the port register |
| dir_sel_i | input | 1 | Selects the direction register |
| ana_sel_i | input | 1 | Selects the analog configuration register |
| wr_en_i | input | 1 | Write strobe for the selected registers |
| op_i | input | 2 | Port write operation: 00 write, 01 set bit, 10 clear bit, 11 none |
| bit_idx_i | input | 3 | Bit index for set and clear |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| pin_i | input | 6 | Raw pin levels |
| pin_oe_o | output | 6 | Per-pin output enable |
| pin_out_o | output | 6 | Per-pin output value |
| tmr_clk_o | output | 1 | Synchronized pin 4 level for a timer clock |

## Verification
The hardest case to reach is a set or clear whose result differs from a latch-based update. Reaching it needs pin levels that disagree with the latch, an analog pin inside the written value, and the open-drain bit switching its enable as a side effect. The stimulus first loads the latch with all ones, then drives different pin patterns and waits out the synchronizer before each bit operation. It then checks the output vectors, which can only match the expected value if the pins were the source. Out-of-range indices and the unused operation code are issued after the pins change, so any spurious write would show up on the outputs.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_SET   = 2'b01,
    OP_CLR   = 2'b10,
    OP_NONE  = 2'b11
  } port_op_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv #(
  parameter int unsigned NUM_PINS = 6,
  parameter int unsigned OD_PIN   = 4
) (
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] lat_i,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] out_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i == OD_PIN) begin : g_od
      // pull low only
      assign oe_o[i]  = ~dir_i[i] & ~lat_i[i];
      assign out_o[i] = 1'b0;
    end else begin : g_pp
      assign oe_o[i]  = ~dir_i[i];
      assign out_o[i] = lat_i[i];
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned          NUM_PINS = 6,
  parameter int unsigned          BUS_W    = 8,
  parameter logic [NUM_PINS-1:0]  ANA_MASK = 6'b101111,
  localparam int unsigned         IDX_W    = $clog2(BUS_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                port_sel_i,
  input  logic                dir_sel_i,
  input  logic                ana_sel_i,
  input  logic                wr_en_i,
  input  logic [1:0]          op_i,
  input  logic [IDX_W-1:0]    bit_idx_i,
  input  logic [BUS_W-1:0]    wdata_i,
  input  logic [NUM_PINS-1:0] rd_val_i,
  output logic [BUS_W-1:0]    rdata_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] lat_o,
  output logic [NUM_PINS-1:0] ana_o
);
  localparam int unsigned PAD_W = BUS_W - NUM_PINS;

  logic [NUM_PINS-1:0] dir_q, lat_q, ana_q, lat_d, bit_mask;
  logic                idx_ok, port_wr;
  port_op_e            op;

  assign op       = port_op_e'(op_i);
  assign idx_ok   = (bit_idx_i < IDX_W'(NUM_PINS));
  assign bit_mask = NUM_PINS'(1) << bit_idx_i;
  assign port_wr  = wr_en_i & port_sel_i;

  always_comb begin
    lat_d = lat_q;
    if (port_wr) begin
      unique case (op)
        OP_WRITE: lat_d = wdata_i[NUM_PINS-1:0];
        OP_SET:   if (idx_ok) lat_d = rd_val_i | bit_mask;
        OP_CLR:   if (idx_ok) lat_d = rd_val_i & ~bit_mask;
        default:  lat_d = lat_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      lat_q <= '0;
      ana_q <= ANA_MASK;
    end else begin
      lat_q <= lat_d;
      if (wr_en_i && dir_sel_i) dir_q <= wdata_i[NUM_PINS-1:0];
      if (wr_en_i && ana_sel_i) ana_q <= wdata_i[NUM_PINS-1:0] & ANA_MASK;
    end
  end

  always_comb begin
    if (port_sel_i)     rdata_o = {{PAD_W{1'b0}}, rd_val_i};
    else if (dir_sel_i) rdata_o = {{PAD_W{1'b0}}, dir_q};
    else if (ana_sel_i) rdata_o = {{PAD_W{1'b0}}, ana_q};
    else                rdata_o = '0;
  end

  assign dir_o = dir_q;
  assign lat_o = lat_q;
  assign ana_o = ana_q;

  // R4
  full_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr && op_i == 2'b00) |=> lat_q == $past(wdata_i[NUM_PINS-1:0]));
  // R5
  set_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr && op_i == 2'b01 && idx_ok) |=> (lat_q & $past(bit_mask)) != '0);
  // R5
  clr_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr && op_i == 2'b10 && idx_ok) |=> (lat_q & $past(bit_mask)) == '0);
  // R5
  bad_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr && op_i != 2'b00 && !idx_ok) |=> $stable(lat_q));
  // R8
  ana_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ana_q & ~ANA_MASK) == '0);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int unsigned         NUM_PINS    = 6,
  parameter int unsigned         BUS_W       = 8,
  parameter int unsigned         OD_PIN      = 4,
  parameter int unsigned         SYNC_STAGES = 2,
  parameter logic [NUM_PINS-1:0] ANA_MASK    = 6'b101111,
  localparam int unsigned        IDX_W       = $clog2(BUS_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                port_sel_i,
  input  logic                dir_sel_i,
  input  logic                ana_sel_i,
  input  logic                wr_en_i,
  input  logic [1:0]          op_i,
  input  logic [IDX_W-1:0]    bit_idx_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic                tmr_clk_o
);
  logic [NUM_PINS-1:0] pin_sync, rd_val, dir_q, lat_q, ana_q;

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  assign rd_val    = pin_sync & ~ana_q;
  assign tmr_clk_o = pin_sync[OD_PIN];

  gpio_port_regs #(.NUM_PINS(NUM_PINS), .BUS_W(BUS_W), .ANA_MASK(ANA_MASK)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .port_sel_i (port_sel_i),
    .dir_sel_i  (dir_sel_i),
    .ana_sel_i  (ana_sel_i),
    .wr_en_i    (wr_en_i),
    .op_i       (op_i),
    .bit_idx_i  (bit_idx_i),
    .wdata_i    (wdata_i),
    .rd_val_i   (rd_val),
    .rdata_o    (rdata_o),
    .dir_o      (dir_q),
    .lat_o      (lat_q),
    .ana_o      (ana_q)
  );

  gpio_pin_drv #(.NUM_PINS(NUM_PINS), .OD_PIN(OD_PIN)) u_drv (
    .dir_i (dir_q),
    .lat_i (lat_q),
    .oe_o  (pin_oe_o),
    .out_o (pin_out_o)
  );

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  // R2
  dir_in_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & dir_q) == '0);
  // R6
  od_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o[OD_PIN] |-> (!lat_q[OD_PIN] && !pin_out_o[OD_PIN]));
  // R8
  ana_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_sel_i && ana_q != '0) |-> (rdata_o[NUM_PINS-1:0] & ana_q) == '0);
  // R7
  tmr_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> tmr_clk_o == $past(pin_i[OD_PIN], 2));
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_sel = 0, dir_sel = 0, ana_sel = 0, wr_en = 0;
  logic [1:0] op = 2'b00;
  logic [2:0] idx = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [5:0] pins = 6'h00, oe, pout;
  logic       tmr;

  always #5 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .port_sel_i(port_sel), .dir_sel_i(dir_sel),
    .ana_sel_i(ana_sel), .wr_en_i(wr_en), .op_i(op), .bit_idx_i(idx),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_oe_o(oe),
    .pin_out_o(pout), .tmr_clk_o(tmr)
  );

  typedef struct {
    int         kind;  // 0 rdata, 1 oe, 2 out, 3 tmr
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // monitor
  initial forever begin
    @(negedge clk);
    #2;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = q.pop_front();
      case (it.kind)
        0: got = rdata;
        1: got = {2'b00, oe};
        2: got = {2'b00, pout};
        default: got = {7'd0, tmr};
      endcase
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d got=%h exp=%h", it.tag, it.kind, got, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [2:0] sel, input logic [7:0] exp,
                     input string tag);
    item_t it;
    @(negedge clk);
    {port_sel, dir_sel, ana_sel} = sel;
    #1;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    #3;
    {port_sel, dir_sel, ana_sel} = 3'b000;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [1:0] o, input logic [2:0] i,
                    input logic [7:0] d);
    @(negedge clk);
    {port_sel, dir_sel, ana_sel} = sel;
    op = o; idx = i; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    {port_sel, dir_sel, ana_sel} = 3'b000;
  endtask

  task automatic set_pins(input logic [5:0] v);
    @(negedge clk);
    pins = v;
    repeat (2) @(negedge clk);
  endtask

  localparam logic [2:0] S_P = 3'b100, S_D = 3'b010, S_A = 3'b001, S_N = 3'b000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(0, S_P, 8'h00, "R1 port");
    chk(0, S_D, 8'h3F, "R1 dir");
    chk(0, S_A, 8'h2F, "R1 ana");
    chk(1, S_N, 8'h00, "R1 oe");
    chk(3, S_N, 8'h00, "R1 tmr");

    // R7 synchronizer latency
    @(negedge clk);
    pins = 6'h3F;
    chk(3, S_N, 8'h00, "R7 tmr after 1 edge");
    chk(3, S_N, 8'h01, "R7 tmr after 2 edges");
    chk(0, S_P, 8'h10, "R8 analog pins read 0");

    // R8 analog register
    wr(S_A, 2'b00, 3'd0, 8'hFF);
    chk(0, S_A, 8'h2F, "R8 ana bit4/7:6 ignored");
    wr(S_A, 2'b00, 3'd0, 8'h00);
    chk(0, S_A, 8'h00, "R8 ana cleared");
    chk(0, S_P, 8'h3F, "R3 digital pins read");

    // R9 / R2
    wr(S_D, 2'b00, 3'd0, 8'hFF);
    chk(0, S_D, 8'h3F, "R9 dir upper bits 0");
    chk(1, S_N, 8'h00, "R2 inputs not driven");

    // R4 full write, R3 read is pins not latch
    wr(S_P, 2'b00, 3'd0, 8'h2A);
    chk(2, S_N, 8'h2A, "R4 latch loaded");
    chk(0, S_P, 8'h3F, "R3 read returns pins");

    // R2 / R6 outputs
    wr(S_D, 2'b00, 3'd0, 8'h00);
    chk(1, S_N, 8'h3F, "R2 R6 all driven");
    wr(S_P, 2'b00, 3'd0, 8'h3F);
    chk(2, S_N, 8'h2F, "R6 od value 0");
    chk(1, S_N, 8'h2F, "R6 od released");

    // R5 read-modify-write from pins
    set_pins(6'h05);
    wr(S_P, 2'b01, 3'd1, 8'h00);
    chk(2, S_N, 8'h07, "R5 set from pins");
    chk(1, S_N, 8'h3F, "R6 od pulls low");
    set_pins(6'h30);
    wr(S_P, 2'b10, 3'd0, 8'h00);
    chk(2, S_N, 8'h20, "R5 clear from pins");
    chk(1, S_N, 8'h2F, "R6 od released again");
    set_pins(6'h00);
    wr(S_P, 2'b01, 3'd6, 8'h00);
    chk(2, S_N, 8'h20, "R5 idx 6 ignored");
    wr(S_P, 2'b10, 3'd7, 8'h00);
    chk(2, S_N, 8'h20, "R5 idx 7 ignored");

    // R8 analog in RMW, R10 driver kept
    wr(S_A, 2'b00, 3'd0, 8'h01);
    set_pins(6'h3F);
    wr(S_P, 2'b01, 3'd5, 8'h00);
    chk(2, S_N, 8'h2E, "R8 analog bit 0 in RMW");
    chk(1, S_N, 8'h2F, "R10 analog pin still driven");
    wr(S_P, 2'b11, 3'd0, 8'h00);
    chk(2, S_N, 8'h2E, "R5 op 11 ignored");

    // R11 mux priority
    chk(0, 3'b110, 8'h3E, "R11 port over dir");
    chk(0, 3'b011, 8'h00, "R11 dir over ana");
    chk(0, S_N, 8'h00, "R11 no select");

    set_pins(6'h2F);
    chk(3, S_N, 8'h00, "R7 tmr low");

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule